// File: doc/BRIEF.md
# Method Write Dispatcher with Macro Call Capture

This block sits behind a command front end and takes one method write per accepted handshake. Each write carries a method index, a data word and the number of parameters that still follow in the same burst. Low method indices are ordinary state. Their values go into a flat register file, which other units read through a combinational port. Two of these indices also raise one-cycle side-effect strobes, one for a draw and one for a query.

High method indices do not go into the register file. They open or continue a macro call. A call is opened by a write to the even slot of a macro entry. It is continued only by writes to the odd slot directly above that entry. Every value of the call is queued in a parameter FIFO, including the opening value. When a write arrives whose remaining count is zero, the call is committed: the parameters become readable, and a start request that carries the entry number and the parameter count is raised. New writes are held off until a macro executor accepts the request.

The block reports protocol violations through a one-cycle error pulse with a code: a bad index, a call opened on an odd slot, an off-sequence write during a call, and parameter storage running out.

Top module: `mthd_dispatch`

## Requirements
- R1: An accepted write to an ordinary method below REG_DEPTH (48) stores its data. The value reads back on `rd_data` for that index from the cycle after acceptance. All words read zero after reset.
- R2: Accepting a write to method 35 raises `draw_pulse`, and a write to method 27 raises `query_pulse`. Each strobe is high for exactly the one cycle after acceptance. No other write raises either strobe.
- R3: Two cases are out of range: an ordinary method from REG_DEPTH up to just below 0xE00, and a method at or above 0xE80. Either one gives `err_valid` with `err_code` 0 in the cycle after acceptance, and it changes no stored word.
- R4: In the idle state, a write to an even method 0xE00 + 2*e (e below 64) opens a call for entry e. That value and every later argument value are queued in arrival order, and `call_count` equals the number of values in the call.
- R5: In the idle state, a write to an odd macro method gives `err_code` 1. It queues nothing and opens no call.
- R6: While a call is open, a write to any method other than the open entry's odd slot gives `err_code` 2. The write is discarded, even if its index is an ordinary one, and the call stays open.
- R7: A call write with remaining count 0 raises `call_valid` in the next cycle, with `call_entry` set to e. The block then returns to idle, so a following write to the odd slot is an error with code 1.
- R8: While `call_valid` is high and `call_ready` is low, `call_valid`, `call_entry` and `call_count` hold. During that time `wr_ready` is low.
- R9: The parameter FIFO holds 32 words. A value arriving when it is full gives `err_code` 3 and discards every value of the call. The rest of the call's argument writes are then absorbed without error until the remaining count reaches 0, and no request is raised.
- R10: `prm_avail` is high only for values of committed calls. Each `prm_pop` while `prm_avail` is high advances `prm_data` to the next value in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Method write offered |
| wr_ready | output | 1 | Method write can be accepted |
| wr_method | input | 12 | Method index |
| wr_data | input | 32 | Method value |
| wr_remain | input | 8 | Parameters still to follow in this burst |
| rd_idx | input | 6 | Register file read index |
| rd_data | output | 32 | Register file read data (zero beyond REG_DEPTH) |
| draw_pulse | output | 1 | Draw side-effect strobe |
| query_pulse | output | 1 | Query side-effect strobe |
| call_valid | output | 1 | Macro start request pending |
| call_ready | input | 1 | Executor accepts the start request |
| call_entry | output | 6 | Macro entry number of the request |
| call_count | output | 6 | Number of parameters of the request |
| prm_pop | input | 1 | Consume the head parameter |
| prm_data | output | 32 | Head parameter value |
| prm_avail | output | 1 | A committed parameter is readable |
| err_valid | output | 1 | Protocol error pulse |
| err_code | output | 2 | 0 range, 1 odd start, 2 off-sequence, 3 overflow |

## Verification
A capture state stuck open or closed is visible at the next write. An argument write would then raise code 1 instead of being accepted, or an ordinary write would raise code 2 instead of storing its value, so the bench sees the fault within one write. A wrong commit or rollback pointer appears at the first pop after the request, as a `prm_avail` or `prm_data` mismatch. A miscounted call appears directly on `call_count` in the cycle the request rises. The random stream interleaves calls, stray writes and overflows, so these states are entered from many predecessors.

// File: rtl/mthd_pkg.sv
package mthd_pkg;

   typedef enum logic [1:0] {
      ERR_RANGE     = 2'd0,
      ERR_ODD_START = 2'd1,
      ERR_SEQUENCE  = 2'd2,
      ERR_OVERFLOW  = 2'd3
   } err_code_e;

   typedef enum logic [1:0] {
      CAP_IDLE    = 2'd0,
      CAP_COLLECT = 2'd1,
      CAP_DISCARD = 2'd2
   } cap_state_e;

endpackage

// File: rtl/mthd_regfile.sv
module mthd_regfile #(
   parameter int IDX_W      = 12,
   parameter int DATA_W     = 32,
   parameter int REG_DEPTH  = 48,
   parameter int DRAW_MTHD  = 35,
   parameter int QUERY_MTHD = 27,
   parameter bit STROBE_REG = 1'b1,
   localparam int RIDX_W    = $clog2(REG_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RIDX_W-1:0] ridx,
   output logic [DATA_W-1:0] rdata,
   output logic              draw_pulse,
   output logic              query_pulse
);

   logic [DATA_W-1:0] words [REG_DEPTH];

   for (genvar g = 0; g < REG_DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (we && (widx == IDX_W'(g)))
            word_q <= wdata;
      end
      assign words[g] = word_q;
   end

   always_comb begin
      rdata = '0;
      if (int'(ridx) < REG_DEPTH)
         rdata = words[ridx];
   end

   logic draw_hit, query_hit;
   assign draw_hit  = we && (widx == IDX_W'(DRAW_MTHD));
   assign query_hit = we && (widx == IDX_W'(QUERY_MTHD));

   if (STROBE_REG) begin : g_strobe_flop
      logic draw_q, query_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            draw_q  <= 1'b0;
            query_q <= 1'b0;
         end else begin
            draw_q  <= draw_hit;
            query_q <= query_hit;
         end
      end
      assign draw_pulse  = draw_q;
      assign query_pulse = query_q;
   end else begin : g_strobe_comb
      assign draw_pulse  = draw_hit;
      assign query_pulse = query_hit;
   end

endmodule

// File: rtl/mthd_prm_fifo.sv
module mthd_prm_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   input  logic              rollback,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              avail,
   output logic              full
);

   logic [AW:0] wptr_q, rptr_q, commit_q;
   logic [AW:0] wptr_inc;
   logic [DATA_W-1:0] slots [DEPTH];

   assign wptr_inc = wptr_q + (AW+1)'(1);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (push && (wptr_q[AW-1:0] == AW'(g)))
            slot_q <= wdata;
      end
      assign slots[g] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q   <= '0;
         rptr_q   <= '0;
         commit_q <= '0;
      end else begin
         if (rollback)
            wptr_q <= commit_q;
         else if (push)
            wptr_q <= wptr_inc;
         if (commit)
            commit_q <= push ? wptr_inc : wptr_q;
         if (pop && avail)
            rptr_q <= rptr_q + (AW+1)'(1);
      end
   end

   assign full  = ((wptr_q - rptr_q) == (AW+1)'(DEPTH));
   assign avail = (rptr_q != commit_q);
   assign rdata = slots[rptr_q[AW-1:0]];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R9
   AST_NO_PUSH_ON_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && rollback)); // R9
   AST_READ_BEHIND_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_q - rptr_q) <= (AW+1)'(DEPTH)); // R10

endmodule

// File: rtl/mthd_capture.sv
module mthd_capture
   import mthd_pkg::*;
#(
   parameter int IDX_W         = 12,
   parameter int REM_W         = 8,
   parameter int REG_DEPTH     = 48,
   parameter int MACRO_BASE    = 'hE00,
   parameter int MACRO_ENTRIES = 64,
   parameter int PRM_DEPTH     = 32,
   localparam int ENTRY_W      = $clog2(MACRO_ENTRIES),
   localparam int CNT_W        = $clog2(PRM_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   output logic               wr_ready,
   input  logic [IDX_W-1:0]   wr_method,
   input  logic [REM_W-1:0]   wr_remain,
   input  logic               fifo_full,
   output logic               reg_we,
   output logic               fifo_push,
   output logic               fifo_commit,
   output logic               fifo_rollback,
   output logic               call_valid,
   input  logic               call_ready,
   output logic [ENTRY_W-1:0] call_entry,
   output logic [CNT_W-1:0]   call_count,
   output logic               err_valid,
   output logic [1:0]         err_code
);

   localparam logic [IDX_W-1:0] MAC_LO  = IDX_W'(MACRO_BASE);
   localparam logic [IDX_W:0]   MAC_END = (IDX_W+1)'(MACRO_BASE + 2*MACRO_ENTRIES);
   localparam logic [IDX_W-1:0] REG_END = IDX_W'(REG_DEPTH);

   cap_state_e          st_q, st_d;
   logic [IDX_W-1:0]    arg_q;
   logic [ENTRY_W-1:0]  entry_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                pend_q;
   logic [ENTRY_W-1:0]  pend_entry_q;
   logic [CNT_W-1:0]    pend_cnt_q;
   logic                err_q;
   err_code_e           code_q;

   logic                acc, last, is_mac, mac_ok, start, take, fire, err_d;
   err_code_e           code_d;
   logic [IDX_W-1:0]    off;
   logic [ENTRY_W-1:0]  new_entry;
   logic [CNT_W-1:0]    cnt_base;

   assign acc       = wr_valid && wr_ready;
   assign last      = (wr_remain == '0);
   assign is_mac    = (wr_method >= MAC_LO);
   assign mac_ok    = ({1'b0, wr_method} < MAC_END);
   assign off       = wr_method - MAC_LO;
   assign new_entry = ENTRY_W'(off >> 1);
   assign cnt_base  = start ? '0 : cnt_q;

   always_comb begin
      st_d          = st_q;
      reg_we        = 1'b0;
      fifo_push     = 1'b0;
      fifo_commit   = 1'b0;
      fifo_rollback = 1'b0;
      start         = 1'b0;
      take          = 1'b0;
      fire          = 1'b0;
      err_d         = 1'b0;
      code_d        = ERR_RANGE;
      if (acc) begin
         case (st_q)
            CAP_IDLE: begin
               if (!is_mac) begin
                  if (wr_method < REG_END) reg_we = 1'b1;
                  else begin err_d = 1'b1; code_d = ERR_RANGE; end
               end else if (!mac_ok) begin
                  err_d = 1'b1; code_d = ERR_RANGE;
               end else if (wr_method[0]) begin
                  err_d = 1'b1; code_d = ERR_ODD_START;
               end else begin
                  start = 1'b1;
                  take  = 1'b1;
               end
            end
            default: begin
               if (wr_method != arg_q) begin
                  err_d = 1'b1; code_d = ERR_SEQUENCE;
               end else
                  take = 1'b1;
            end
         endcase
         if (take) begin
            if (st_q == CAP_DISCARD) begin
               if (last) st_d = CAP_IDLE;
            end else if (fifo_full) begin
               err_d         = 1'b1;
               code_d        = ERR_OVERFLOW;
               fifo_rollback = 1'b1;
               st_d          = last ? CAP_IDLE : CAP_DISCARD;
            end else begin
               fifo_push = 1'b1;
               if (last) begin
                  fifo_commit = 1'b1;
                  fire        = 1'b1;
                  st_d        = CAP_IDLE;
               end else
                  st_d = CAP_COLLECT;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= CAP_IDLE;
         arg_q        <= '0;
         entry_q      <= '0;
         cnt_q        <= '0;
         pend_q       <= 1'b0;
         pend_entry_q <= '0;
         pend_cnt_q   <= '0;
         err_q        <= 1'b0;
         code_q       <= ERR_RANGE;
      end else begin
         st_q   <= st_d;
         err_q  <= err_d;
         code_q <= code_d;
         if (start) begin
            arg_q   <= wr_method + IDX_W'(1);
            entry_q <= new_entry;
         end
         if (fifo_push)
            cnt_q <= cnt_base + CNT_W'(1);
         if (fire) begin
            pend_q       <= 1'b1;
            pend_entry_q <= start ? new_entry : entry_q;
            pend_cnt_q   <= cnt_base + CNT_W'(1);
         end else if (pend_q && call_ready)
            pend_q <= 1'b0;
      end
   end

   assign wr_ready   = !pend_q;
   assign call_valid = pend_q;
   assign call_entry = pend_entry_q;
   assign call_count = pend_cnt_q;
   assign err_valid  = err_q;
   assign err_code   = code_q;

   AST_CALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      call_valid && !call_ready |=> call_valid && $stable(call_entry) && $stable(call_count)); // R8
   AST_QUIET_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      call_valid |-> !reg_we && !fifo_push && !fifo_rollback); // R8
   AST_CALL_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      call_valid |-> (call_count != '0) && (call_count <= CNT_W'(PRM_DEPTH))); // R4
   AST_FIRE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_valid) |-> $past(wr_valid && (wr_remain == '0))); // R7

endmodule

// File: rtl/mthd_dispatch.sv
module mthd_dispatch #(
   parameter int IDX_W         = 12,
   parameter int DATA_W        = 32,
   parameter int REM_W         = 8,
   parameter int REG_DEPTH     = 48,
   parameter int DRAW_MTHD     = 35,
   parameter int QUERY_MTHD    = 27,
   parameter int MACRO_BASE    = 'hE00,
   parameter int MACRO_ENTRIES = 64,
   parameter int PRM_DEPTH     = 32,
   parameter bit STROBE_REG    = 1'b1,
   localparam int RIDX_W       = $clog2(REG_DEPTH),
   localparam int ENTRY_W      = $clog2(MACRO_ENTRIES),
   localparam int CNT_W        = $clog2(PRM_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   output logic               wr_ready,
   input  logic [IDX_W-1:0]   wr_method,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [REM_W-1:0]   wr_remain,
   input  logic [RIDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0]  rd_data,
   output logic               draw_pulse,
   output logic               query_pulse,
   output logic               call_valid,
   input  logic               call_ready,
   output logic [ENTRY_W-1:0] call_entry,
   output logic [CNT_W-1:0]   call_count,
   input  logic               prm_pop,
   output logic [DATA_W-1:0]  prm_data,
   output logic               prm_avail,
   output logic               err_valid,
   output logic [1:0]         err_code
);

   if (PRM_DEPTH < 2 || (PRM_DEPTH & (PRM_DEPTH - 1)) != 0) begin : g_chk_depth
      $error("PRM_DEPTH must be a power of two of at least 2");
   end
   if (REG_DEPTH > MACRO_BASE) begin : g_chk_regs
      $error("register file overlaps the macro method range");
   end
   if ((MACRO_BASE % 2) != 0) begin : g_chk_base
      $error("MACRO_BASE must be even");
   end
   if (MACRO_BASE + 2*MACRO_ENTRIES > (1 << IDX_W)) begin : g_chk_space
      $error("macro range exceeds the method index space");
   end
   if (DRAW_MTHD >= REG_DEPTH || QUERY_MTHD >= REG_DEPTH || DRAW_MTHD == QUERY_MTHD) begin : g_chk_strobe
      $error("strobe methods must be distinct ordinary methods");
   end

   logic reg_we, fifo_push, fifo_commit, fifo_rollback, fifo_full;

   mthd_capture #(
      .IDX_W(IDX_W), .REM_W(REM_W), .REG_DEPTH(REG_DEPTH),
      .MACRO_BASE(MACRO_BASE), .MACRO_ENTRIES(MACRO_ENTRIES), .PRM_DEPTH(PRM_DEPTH)
   ) u_capture (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_method(wr_method), .wr_remain(wr_remain),
      .fifo_full(fifo_full), .reg_we(reg_we),
      .fifo_push(fifo_push), .fifo_commit(fifo_commit), .fifo_rollback(fifo_rollback),
      .call_valid(call_valid), .call_ready(call_ready),
      .call_entry(call_entry), .call_count(call_count),
      .err_valid(err_valid), .err_code(err_code)
   );

   mthd_regfile #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .REG_DEPTH(REG_DEPTH),
      .DRAW_MTHD(DRAW_MTHD), .QUERY_MTHD(QUERY_MTHD), .STROBE_REG(STROBE_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we), .widx(wr_method), .wdata(wr_data),
      .ridx(rd_idx), .rdata(rd_data),
      .draw_pulse(draw_pulse), .query_pulse(query_pulse)
   );

   mthd_prm_fifo #(
      .DATA_W(DATA_W), .DEPTH(PRM_DEPTH)
   ) u_params (
      .clk(clk), .rst_n(rst_n),
      .push(fifo_push), .wdata(wr_data),
      .commit(fifo_commit), .rollback(fifo_rollback),
      .pop(prm_pop), .rdata(prm_data),
      .avail(prm_avail), .full(fifo_full)
   );

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !((draw_pulse || query_pulse) && err_valid)); // R2

endmodule

// File: tb/mthd_dispatch_tb_top.sv
`timescale 1ns/1ps
module mthd_dispatch_tb_top;

   localparam int REGS  = 48;
   localparam int DRAW  = 35;
   localparam int QUERY = 27;
   localparam int BASE  = 'hE00;
   localparam int MEND  = 'hE80;
   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [11:0] wr_method = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  wr_remain = '0;
   logic [5:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        draw_pulse, query_pulse;
   logic        call_valid;
   logic        call_ready = 1'b0;
   logic [5:0]  call_entry;
   logic [5:0]  call_count;
   logic        prm_pop = 1'b0;
   logic [31:0] prm_data;
   logic        prm_avail;
   logic        err_valid;
   logic [1:0]  err_code;

   always #2 clk = ~clk;

   mthd_dispatch dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_method(wr_method), .wr_data(wr_data), .wr_remain(wr_remain),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .draw_pulse(draw_pulse), .query_pulse(query_pulse),
      .call_valid(call_valid), .call_ready(call_ready),
      .call_entry(call_entry), .call_count(call_count),
      .prm_pop(prm_pop), .prm_data(prm_data), .prm_avail(prm_avail),
      .err_valid(err_valid), .err_code(err_code)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   logic [31:0] m_regs [REGS];
   int          m_st = 0;      // 0 idle, 1 collecting, 2 discarding
   int          m_arg = 0;
   int          m_entry = 0;
   int          m_cnt = 0;
   logic [31:0] m_q [$];
   int          r_left = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   function automatic int rel_err_req(input int code);
      case (code)
         0: return 3;
         1: return 5;
         2: return 6;
         default: return 9;
      endcase
   endfunction

   // R8 R10: hold the request, then accept it and drain the parameters
   task automatic drain(input int exp_entry, input int exp_cnt);
      int w;
      w = int'($urandom_range(0, 3));
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         chk("R8 hold valid", 32'(call_valid), 32'd1);
         chk("R8 ready low", 32'(wr_ready), 32'd0);
         chk("R8 entry stable", 32'(call_entry), 32'(exp_entry));
         chk("R8 count stable", 32'(call_count), 32'(exp_cnt));
      end
      call_ready = 1'b1;
      @(negedge clk);
      call_ready = 1'b0;
      chk("R8 released", 32'(call_valid), 32'd0);
      chk("R8 ready back", 32'(wr_ready), 32'd1);
      foreach (m_q[i]) begin
         chk("R10 avail", 32'(prm_avail), 32'd1);
         chk("R4 R10 param order", prm_data, m_q[i]);
         prm_pop = 1'b1;
         @(negedge clk);
         prm_pop = 1'b0;
      end
      chk("R10 drained", 32'(prm_avail), 32'd0);
      m_q.delete();
   endtask

   task automatic send(input int m, input logic [31:0] d, input int rem);
      bit e_err = 0;
      int e_code = 0;
      bit e_draw = 0, e_query = 0, e_fire = 0;
      int e_ent = 0, e_cnt = 0;
      bit take = 0;
      logic [5:0] ri;
      // model
      if (m_st == 0) begin
         if (m < BASE) begin
            if (m < REGS) begin
               m_regs[m] = d;
               e_draw = (m == DRAW);
               e_query = (m == QUERY);
            end else begin e_err = 1; e_code = 0; end
         end else if (m >= MEND) begin e_err = 1; e_code = 0; end
         else if (m % 2 == 1) begin e_err = 1; e_code = 1; end
         else begin
            m_entry = (m - BASE) / 2;
            m_arg = m + 1;
            m_cnt = 0;
            m_q.delete();
            m_st = 1;
            take = 1;
         end
      end else if (m != m_arg) begin e_err = 1; e_code = 2; end
      else take = 1;
      if (take) begin
         if (m_st == 2) begin
            if (rem == 0) m_st = 0;
         end else if (m_cnt == DEPTH) begin
            e_err = 1; e_code = 3;
            m_q.delete();
            m_st = (rem == 0) ? 0 : 2;
         end else begin
            m_q.push_back(d);
            m_cnt++;
            if (rem == 0) begin
               e_fire = 1; e_ent = m_entry; e_cnt = m_cnt; m_st = 0;
            end
         end
      end
      // drive
      @(negedge clk);
      wr_valid = 1'b1; wr_method = 12'(m); wr_data = d; wr_remain = 8'(rem);
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      ri = 6'($urandom_range(0, REGS - 1));
      if ($urandom_range(0, 1) == 1 && m < REGS) ri = 6'(m);
      rd_idx = ri;
      #0.5;
      chk("R1 readback", rd_data, m_regs[ri]);
      chk("R3 R5 R6 R9 error flag", 32'(err_valid), 32'(e_err));
      if (e_err)
         chk($sformatf("R%0d error code", rel_err_req(e_code)), 32'(err_code), 32'(e_code));
      chk("R2 draw strobe", 32'(draw_pulse), 32'(e_draw));
      chk("R2 query strobe", 32'(query_pulse), 32'(e_query));
      chk("R7 request raised", 32'(call_valid), 32'(e_fire));
      if (m_st != 0 || !e_fire)
         chk("R10 uncommitted hidden", 32'(prm_avail), 32'd0);
      if (e_fire) begin
         chk("R7 call entry", 32'(call_entry), 32'(e_ent));
         chk("R4 call count", 32'(call_count), 32'(e_cnt));
         drain(e_ent, e_cnt);
      end
   endtask

   task automatic macro_call(input int entry, input int nvals);
      send(BASE + 2*entry, $urandom, nvals - 1);
      for (int k = nvals - 2; k >= 0; k--)
         send(BASE + 2*entry + 1, $urandom, k);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < REGS; i++) m_regs[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R8 reset ready", 32'(wr_ready), 32'd1);
      chk("R7 reset idle", 32'(call_valid), 32'd0);
      chk("R10 reset empty", 32'(prm_avail), 32'd0);
      chk("R3 reset no error", 32'(err_valid), 32'd0);
      rd_idx = 6'd47; #0.5;
      chk("R1 reset word", rd_data, 32'd0);

      // R1 R2 directed
      send(0, 32'hA5A5_0001, 0);
      send(47, 32'h1234_5678, 3);
      send(DRAW, 32'h0000_0D0D, 0);
      send(QUERY, 32'h0000_0E0E, 0);
      // R3 range errors, neighbours must not change
      send(REGS, 32'hDEAD_BEEF, 0);
      send(BASE - 1, 32'hDEAD_BEEF, 0);
      send(MEND, 32'hDEAD_BEEF, 0);
      send('hFFF, 32'hDEAD_BEEF, 0);
      // R5 odd first write
      send(BASE + 1, 32'h1111_1111, 2);
      // R4 R7 calls: single value, several values, last entry
      macro_call(0, 1);
      macro_call(5, 4);
      macro_call(63, 3);
      // R7 idle after the call: odd slot now errors
      send(BASE + 127, 32'h2222_2222, 0);
      // R6 stray writes mid-call, including an ordinary index
      send(BASE + 20, 32'h3000_0000, 3);
      send(3, 32'hBAD0_0003, 0);
      send(BASE + 22, 32'hBAD0_0022, 0);
      send(BASE + 21, 32'h3000_0001, 2);
      send(BASE + 21, 32'h3000_0002, 1);
      send(BASE + 21, 32'h3000_0003, 0);
      // R9 full FIFO exactly, then overflow with absorbed tail
      macro_call(7, DEPTH);
      macro_call(9, DEPTH + 3);
      send(BASE + 1, 32'h4444_4444, 0);
      macro_call(2, 2);

      // constrained random stream
      for (int it = 0; it < 3000; it++) begin
         int cls, m, rem;
         if (m_st != 0 && $urandom_range(0, 9) != 0) begin
            r_left = (r_left > 0) ? r_left - 1 : 0;
            send(m_arg, $urandom, r_left);
         end else begin
            cls = int'($urandom_range(0, 9));
            rem = ($urandom_range(0, 19) == 0) ? int'($urandom_range(30, 40))
                                                : int'($urandom_range(0, 6));
            case (cls)
               0, 1, 2: m = int'($urandom_range(0, REGS - 1));
               3:       m = ($urandom_range(0, 1) == 1) ? DRAW : QUERY;
               4:       m = int'($urandom_range(REGS, BASE - 1));
               5, 6, 7: m = BASE + 2 * int'($urandom_range(0, 63));
               8:       m = BASE + 1 + 2 * int'($urandom_range(0, 63));
               default: m = int'($urandom_range(MEND, 'hFFF));
            endcase
            if (m_st == 0 && m >= BASE && m < MEND && m % 2 == 0) r_left = rem;
            send(m, $urandom, rem);
         end
      end
      // close any open call
      while (m_st != 0) begin
         r_left = (r_left > 0) ? r_left - 1 : 0;
         send(m_arg, $urandom, r_left);
      end
      finish_run();
   end

endmodule